// File: doc/BRIEF.md
# Sliding-Scale Channel Width Corrector

A pulse-height analyzer's converter rarely has channels of equal width, so a peak that sits on one narrow code is broadened or split. This block spreads each event over a different stretch of the converter's transfer curve. An 8-bit binary up-counter with plain 8-4-2-1 weighting drives an external DAC. That DAC's output is summed with the held analog peak before the converter samples it. When the 13-bit raw result comes back, the block removes the same offset digitally and presents the corrected channel number.

A conversion begins with a start handshake. At that moment the block captures the counter value in effect for the conversion, and the raw result is later reduced by this captured value rather than by the live counter. Each accepted raw result steps the counter by one, wrapping at the top. The step happens only at the end of a conversion, so the DAC code never moves while the converter is busy. A raw result smaller than its offset cannot map to a real channel. It is discarded, and a one-cycle underflow flag is raised instead. Corrected results leave through a valid/ready output that can stall the converter side.

Top module: `sliding_scale_corrector`

## Requirements
- R1: A synchronous active-high reset sets dac_code to 0, out_valid and underflow to 0, start_ready to 1 and raw_ready to 0.
- R2: dac_code is an 8-bit counter that rises by exactly one after each accepted raw result (raw_valid and raw_ready high at a clock edge), counting discarded events too, and wraps from 255 to 0.
- R3: While a conversion is in progress (start_ready low), dac_code does not change.
- R4: One clock after a raw result is accepted with raw_data not below the captured offset, out_valid is 1 and out_chan equals raw_data minus the dac_code value captured at the start handshake; equal values give channel 0.
- R5: If the accepted raw_data is below the captured offset, underflow is 1 for exactly that one following cycle and no output is produced (out_valid 0).
- R6: start_ready is high exactly when no conversion is in progress; a start handshake makes it low on the next cycle. raw_ready is high only during a conversion and only when the output slot is empty or being drained in the same cycle.
- R7: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_chan holds its value.
- R8: A raw result may be accepted in the same cycle that the previous corrected result is drained; the new channel then appears on the next cycle without a gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_valid | input | 1 | Peak detected, request to begin a conversion |
| start_ready | output | 1 | No conversion in progress, start may be taken |
| dac_code | output | 8 | Offset code for the external DAC |
| raw_valid | input | 1 | Converter result present |
| raw_ready | output | 1 | Block can take the converter result |
| raw_data | input | 13 | Raw converter result |
| out_valid | output | 1 | Corrected channel present |
| out_ready | input | 1 | Downstream takes the corrected channel |
| out_chan | output | 13 | Corrected channel number |
| underflow | output | 1 | One-cycle pulse: event discarded, raw below offset |

## Verification
The two functions that can fall in one cycle are the drain of a held corrected channel and the capture of the next raw result into the same output register. The bench holds out_ready low so that a first result stays parked, then starts a second conversion and presents its raw value. It confirms that raw_ready stays low and the parked channel is intact. It then raises out_ready while raw_valid is still high, and on the following cycle expects out_valid to remain high with the second, offset-corrected channel and the counter advanced by one.

// File: rtl/ssc_pkg.sv
package ssc_pkg;

    localparam int CH_W  = 13;
    localparam int OFS_W = 8;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_CONV = 1'b1
    } conv_phase_e;

    typedef enum logic [1:0] {
        EV_NONE    = 2'd0,
        EV_CHANNEL = 2'd1,
        EV_DROP    = 2'd2
    } event_kind_e;

    function automatic event_kind_e classify(input logic fire, input logic below);
        if (!fire)      return EV_NONE;
        else if (below) return EV_DROP;
        else            return EV_CHANNEL;
    endfunction

endpackage

// File: rtl/ssc_offset_counter.sv
module ssc_offset_counter #(
    parameter int OFS_W = ssc_pkg::OFS_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             advance,
    output logic [OFS_W-1:0] code
);
    logic [OFS_W-1:0] count_q;

    always_ff @(posedge clk) begin
        if (rst)
            count_q <= '0;
        else if (advance)
            count_q <= count_q + OFS_W'(1);
    end

    assign code = count_q;
endmodule

// File: rtl/ssc_conv_tracker.sv
module ssc_conv_tracker #(
    parameter int OFS_W = ssc_pkg::OFS_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_valid,
    output logic             start_ready,
    input  logic             raw_valid,
    input  logic             slot_free,
    output logic             raw_ready,
    output logic             raw_fire,
    input  logic [OFS_W-1:0] live_ofs,
    output logic [OFS_W-1:0] held_ofs
);
    import ssc_pkg::*;

    conv_phase_e      phase_q;
    logic [OFS_W-1:0] held_q;
    logic             start_fire;

    assign start_ready = (phase_q == PH_IDLE);
    assign start_fire  = start_valid && start_ready;
    assign raw_ready   = (phase_q == PH_CONV) && slot_free;
    assign raw_fire    = raw_valid && raw_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            held_q  <= '0;
        end else begin
            if (start_fire) begin
                phase_q <= PH_CONV;
                held_q  <= live_ofs;
            end else if (raw_fire) begin
                phase_q <= PH_IDLE;
            end
        end
    end

    assign held_ofs = held_q;
endmodule

// File: rtl/ssc_subtract.sv
module ssc_subtract #(
    parameter int CH_W  = ssc_pkg::CH_W,
    parameter int OFS_W = ssc_pkg::OFS_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             raw_fire,
    input  logic [CH_W-1:0]  raw_data,
    input  logic [OFS_W-1:0] held_ofs,
    input  logic             out_ready,
    output logic             out_valid,
    output logic [CH_W-1:0]  out_chan,
    output logic             underflow,
    output logic             slot_free
);
    import ssc_pkg::*;

    typedef struct packed {
        logic            below;
        logic [CH_W-1:0] chan;
    } corr_t;

    corr_t       corr;
    event_kind_e kind;
    logic [CH_W-1:0] ofs_ext;
    logic        valid_q;
    logic        uf_q;
    logic [CH_W-1:0] chan_q;

    assign ofs_ext    = CH_W'(held_ofs);
    assign corr.below = raw_data < ofs_ext;
    assign corr.chan  = raw_data - ofs_ext;
    assign kind       = classify(raw_fire, corr.below);
    assign slot_free  = !valid_q || out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            uf_q    <= 1'b0;
            chan_q  <= '0;
        end else begin
            uf_q <= (kind == EV_DROP);
            if (kind == EV_CHANNEL) begin
                valid_q <= 1'b1;
                chan_q  <= corr.chan;
            end else if (out_ready) begin
                valid_q <= 1'b0;
            end
        end
    end

    assign out_valid = valid_q;
    assign out_chan  = chan_q;
    assign underflow = uf_q;
endmodule

// File: rtl/sliding_scale_corrector.sv
module sliding_scale_corrector #(
    parameter int CH_W  = ssc_pkg::CH_W,
    parameter int OFS_W = ssc_pkg::OFS_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_valid,
    output logic             start_ready,
    output logic [OFS_W-1:0] dac_code,
    input  logic             raw_valid,
    output logic             raw_ready,
    input  logic [CH_W-1:0]  raw_data,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [CH_W-1:0]  out_chan,
    output logic             underflow
);
    logic             raw_fire;
    logic             slot_free;
    logic [OFS_W-1:0] held_ofs;

    ssc_offset_counter #(.OFS_W(OFS_W)) ctr_i (
        .clk     (clk),
        .rst     (rst),
        .advance (raw_fire),
        .code    (dac_code)
    );

    ssc_conv_tracker #(.OFS_W(OFS_W)) trk_i (
        .clk         (clk),
        .rst         (rst),
        .start_valid (start_valid),
        .start_ready (start_ready),
        .raw_valid   (raw_valid),
        .slot_free   (slot_free),
        .raw_ready   (raw_ready),
        .raw_fire    (raw_fire),
        .live_ofs    (dac_code),
        .held_ofs    (held_ofs)
    );

    ssc_subtract #(.CH_W(CH_W), .OFS_W(OFS_W)) sub_i (
        .clk       (clk),
        .rst       (rst),
        .raw_fire  (raw_fire),
        .raw_data  (raw_data),
        .held_ofs  (held_ofs),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_chan  (out_chan),
        .underflow (underflow),
        .slot_free (slot_free)
    );
endmodule

// File: rtl/ssc_checker.sv
module ssc_checker #(
    parameter int CH_W  = ssc_pkg::CH_W,
    parameter int OFS_W = ssc_pkg::OFS_W
) (
    input logic             clk,
    input logic             rst,
    input logic             start_valid,
    input logic             start_ready,
    input logic [OFS_W-1:0] dac_code,
    input logic             raw_valid,
    input logic             raw_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic [CH_W-1:0]  out_chan,
    input logic             underflow
);
    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst) $past(rst) |-> (!out_valid && !underflow && dac_code == '0 && start_ready && !raw_ready)); // R1
    AST_DAC_STEP: assert property (@(posedge clk) disable iff (rst) (raw_valid && raw_ready) |=> (dac_code == OFS_W'($past(dac_code) + OFS_W'(1)))); // R2
    AST_DAC_STILL_BUSY: assert property (@(posedge clk) disable iff (rst) (!start_ready && !$past(start_ready)) |-> $stable(dac_code)); // R3
    AST_DROP_NO_OUTPUT: assert property (@(posedge clk) disable iff (rst) underflow |-> !out_valid); // R5
    AST_START_CLOSES: assert property (@(posedge clk) disable iff (rst) (start_valid && start_ready) |=> !start_ready); // R6
    AST_RAW_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst) raw_ready |-> !start_ready); // R6
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst) (out_valid && !out_ready) |=> (out_valid && $stable(out_chan))); // R7
endmodule

bind sliding_scale_corrector ssc_checker #(.CH_W(CH_W), .OFS_W(OFS_W)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .start_valid (start_valid),
    .start_ready (start_ready),
    .dac_code    (dac_code),
    .raw_valid   (raw_valid),
    .raw_ready   (raw_ready),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_chan    (out_chan),
    .underflow   (underflow)
);

// File: tb/sliding_scale_corrector_tb.sv
`timescale 1ns/1ps
module sliding_scale_corrector_tb_top;
    localparam int CH_W  = 13;
    localparam int OFS_W = 8;
    localparam int NV    = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start_valid = 1'b0;
    logic             start_ready;
    logic [OFS_W-1:0] dac_code;
    logic             raw_valid = 1'b0;
    logic             raw_ready;
    logic [CH_W-1:0]  raw_data = '0;
    logic             out_valid;
    logic             out_ready = 1'b1;
    logic [CH_W-1:0]  out_chan;
    logic             underflow;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // {expect_underflow, raw, expected channel}; offset of entry i is i after reset
    localparam logic [2*CH_W:0] VEC [NV] = '{
        {1'b0, 13'd100,  13'd100},
        {1'b1, 13'd0,    13'd0},
        {1'b0, 13'd8191, 13'd8189},
        {1'b0, 13'd3,    13'd0},
        {1'b0, 13'd1000, 13'd996},
        {1'b1, 13'd4,    13'd0},
        {1'b0, 13'd6,    13'd0},
        {1'b0, 13'd4096, 13'd4089}
    };

    always #4 clk = ~clk;

    sliding_scale_corrector #(.CH_W(CH_W), .OFS_W(OFS_W)) dut_i (
        .clk(clk), .rst(rst), .start_valid(start_valid), .start_ready(start_ready),
        .dac_code(dac_code), .raw_valid(raw_valid), .raw_ready(raw_ready),
        .raw_data(raw_data), .out_valid(out_valid), .out_ready(out_ready),
        .out_chan(out_chan), .underflow(underflow)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic do_start();
        start_valid = 1'b1;
        tick();
        start_valid = 1'b0;
    endtask

    task automatic do_raw(input logic [CH_W-1:0] v);
        raw_valid = 1'b1;
        raw_data  = v;
        tick();
        raw_valid = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        tick();
        tick();
        rst = 1'b0;
        tick();
    endtask

    initial begin
        do_reset();
        // R1 reset state
        check(dac_code == 0, "R1 dac_code", dac_code, 0);
        check(!out_valid && !underflow, "R1 out_valid/underflow", out_valid + underflow, 0);
        check(start_ready && !raw_ready, "R1 start_ready/raw_ready", {start_ready, raw_ready}, 2);

        // table walk: R4 channels, R5 underflow drops, R2 step per event
        for (int i = 0; i < NV; i++) begin
            check(start_ready, "R6 start_ready idle", start_ready, 1);
            do_start();
            check(!start_ready, "R6 start_ready busy", start_ready, 0);
            check(dac_code == i, "R3 dac held at start", dac_code, i);
            do_raw(VEC[i][2*CH_W-1:CH_W]);
            if (VEC[i][2*CH_W]) begin
                check(underflow && !out_valid, "R5 drop", {underflow, out_valid}, 2);
            end else begin
                check(out_valid && !underflow, "R4 valid", {out_valid, underflow}, 2);
                check(out_chan == VEC[i][CH_W-1:0], "R4 channel", out_chan, VEC[i][CH_W-1:0]);
            end
            check(dac_code == i + 1, "R2 step", dac_code, i + 1);
        end
        tick();
        check(!underflow && !out_valid, "R5 single pulse", {underflow, out_valid}, 0);

        // R2 wrap from 255 to 0
        for (int k = 0; k < 247; k++) begin
            do_start();
            do_raw(13'd8191);
        end
        check(dac_code == 255, "R2 reach top", dac_code, 255);
        do_start();
        do_raw(13'd300);
        check(out_chan == 45, "R4 top offset", out_chan, 45);
        check(dac_code == 0, "R2 wrap", dac_code, 0);
        tick();

        // R7 hold, R6 raw stall, R8 drain and capture same cycle
        do_reset();
        out_ready = 1'b0;
        do_start();
        do_raw(13'd500);
        check(out_valid && out_chan == 500, "R4 first parked", out_chan, 500);
        tick();
        tick();
        check(out_valid && out_chan == 500, "R7 hold", out_chan, 500);
        do_start();
        raw_valid = 1'b1;
        raw_data  = 13'd700;
        check(!raw_ready, "R6 raw stalled", raw_ready, 0);
        tick();
        check(out_chan == 500 && out_valid, "R7 still parked", out_chan, 500);
        check(dac_code == 1, "R3 dac stable stalled", dac_code, 1);
        out_ready = 1'b1;
        tick();
        raw_valid = 1'b0;
        check(out_valid, "R8 no gap", out_valid, 1);
        check(out_chan == 699, "R8 new channel", out_chan, 699);
        check(dac_code == 2, "R2 step after stall", dac_code, 2);
        tick();
        check(!out_valid, "R7 drained", out_valid, 0);

        // R1 reset while output held
        out_ready = 1'b0;
        do_start();
        do_raw(13'd50);
        check(out_valid, "R4 before reset", out_valid, 1);
        rst = 1'b1;
        tick();
        rst = 1'b0;
        check(!out_valid && dac_code == 0, "R1 mid-run reset", {out_valid, dac_code}, 0);
        out_ready = 1'b1;
        tick();

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        #1000000;
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule